// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A small synchronous up-counter stage, four bits wide by default, built to be chained into wider counters. On each rising clock edge it either clears, loads a parallel preset word, advances by one, or holds, chosen by a fixed priority among its control inputs. Two active-high enables must both be high for the stage to advance. Only one of them, the carry enable, also qualifies the carry output.

The carry output is combinational. It is high while the carry enable is high and the stored value is all ones. In a chain, each stage's carry output drives the next stage's carry enable. The count enable is shared by all stages. The carry therefore ripples through the gating logic rather than through registers, and the whole chain steps as one wide counter. A parameter selects whether the active-low clear acts at once, independent of the clock, or only on a rising edge.

Top module: `cascade_counter`

## Requirements
- R1: While `load_n` is low and `clr_n` is high, a rising edge writes `din` into `count`, whatever the two enables are.
- R2: While `load_n` and `clr_n` are high and both `cnt_en` and `carry_en` are high, a rising edge adds one to `count`.
- R3: While `load_n` and `clr_n` are high and either enable is low, `count` keeps its value across the edge.
- R4: Advancing from the all-ones value gives zero. No flag is raised beyond the carry output.
- R5: `carry_out` is 1 exactly when `carry_en` is 1 and `count` is all ones. `cnt_en` has no effect on it.
- R6: With `ASYNC_CLEAR` = 1, a low `clr_n` forces `count` to zero at once, without a clock edge and regardless of the other inputs.
- R7: With `ASYNC_CLEAR` = 0, a low `clr_n` leaves `count` unchanged until the next rising edge, which then sets it to zero.
- R8: The priority order is clear, then load, then count, then hold.
- R9: Three stages chained this way (each stage's `carry_out` drives the next stage's `carry_en`, with `cnt_en` shared) behave as one 12-bit counter. The top carry is high for exactly one cycle at value 0xFFF.
- R10: Clearing, presetting 12 and then counting gives 13, 14, 15, 0, 1, 2 in the low stage. After that the stage holds while counting is inhibited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous by `ASYNC_CLEAR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable; does not affect the carry output |
| carry_en | input | 1 | Count enable that also qualifies `carry_out` |
| din | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when `carry_en` is high and `count` is all ones |

## Verification
Two three-stage chains are driven side by side, one built with each clear variant, and are compared against a single 12-bit model. Random mixes of clears, loads and enable patterns separate the priority order from a naive ordering. Runs where only `cnt_en` is dropped, or only `carry_en`, show that only the carry enable gates the carry. A clear dropped halfway through a cycle makes the asynchronous chain read zero while the synchronous chain still reads its old value. A preset just below 0xFFF drives the carry through all three stages and checks the 12-bit wrap.

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             carry_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic             advance;
  logic [WIDTH-1:0] next_count;

  assign advance    = cnt_en && carry_en;
  assign next_count = !load_n ? din : advance ? count + 1'b1 : count;
  assign carry_out  = carry_en && (count == ALL_ONES);

  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) count <= '0;
        else        count <= next_count;

      assert_clear_async_R6: assert property (@(posedge clk)
        !clr_n |-> count == '0);
    end else begin : g_sync
      always_ff @(posedge clk)
        if (!clr_n) count <= '0;
        else        count <= next_count;

      assert_clear_sync_R7: assert property (@(posedge clk)
        !clr_n |=> count == '0);
    end
  endgenerate

  assert_load_R1: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(din));

  assert_count_R2: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && cnt_en && carry_en |=> count == WIDTH'($past(count) + 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && !(cnt_en && carry_en) |=> $stable(count));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && cnt_en && carry_out |=> count == '0);

endmodule

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        clr_n = 1'b0;
  logic        load_n = 1'b1;
  logic        par = 1'b0;
  logic        trk = 1'b0;
  logic [11:0] din12 = '0;

  logic [11:0] cnt_a, cnt_s;
  logic [2:0]  co_a, co_s;

  int checks = 0;
  int errors = 0;
  logic [11:0] model = '0;

  for (genvar k = 0; k < 3; k++) begin : g_chain
    logic ce_a, ce_s;
    if (k == 0) begin : g_first
      assign ce_a = trk;
      assign ce_s = trk;
    end else begin : g_next
      assign ce_a = co_a[k-1];
      assign ce_s = co_s[k-1];
    end
    cascade_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) u_a (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(par), .carry_en(ce_a),
      .din(din12[4*k +: 4]), .count(cnt_a[4*k +: 4]), .carry_out(co_a[k]));
    cascade_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_s (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(par), .carry_en(ce_s),
      .din(din12[4*k +: 4]), .count(cnt_s[4*k +: 4]), .carry_out(co_s[k]));
  end

  // the single-stage instance the style names; the chains above carry the checks
  logic [3:0] solo_cnt;
  logic       solo_co;
  cascade_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(par), .carry_en(trk),
    .din(din12[3:0]), .count(solo_cnt), .carry_out(solo_co));

  function automatic logic [2:0] exp_carry(input logic [11:0] v, input logic t);
    exp_carry[0] = t && (v[3:0] == 4'hF);
    exp_carry[1] = t && (v[7:0] == 8'hFF);
    exp_carry[2] = t && (v == 12'hFFF);
  endfunction

  function automatic logic [11:0] next_model(input logic [11:0] v, input logic c,
                                             input logic l, input logic p,
                                             input logic t, input logic [11:0] d);
    if (!c)          return '0;
    else if (!l)     return d;
    else if (p && t) return v + 12'd1;
    else             return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [2:0] ec;
    ec = exp_carry(model, trk);
    chk(cnt_a == model, {tag, " async count"}, {4'h0, cnt_a}, {4'h0, model});
    chk(cnt_s == model, {tag, " sync count"}, {4'h0, cnt_s}, {4'h0, model});
    chk(co_a == ec, {tag, " R5 R9 async carry"}, {13'h0, co_a}, {13'h0, ec});
    chk(co_s == ec, {tag, " R5 R9 sync carry"}, {13'h0, co_s}, {13'h0, ec});
  endtask

  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [11:0] d, input string tag);
    @(negedge clk);
    clr_n = c; load_n = l; par = p; trk = t; din12 = d;
    @(posedge clk);
    model = next_model(model, c, l, p, t, d);
    #1;
    compare_all(tag);
  endtask

  function automatic string mode_tag(input logic c, input logic l, input logic p,
                                     input logic t);
    if (!c)          return "R6 R7 R8 clear";
    else if (!l)     return "R1 R8 load";
    else if (p && t) return "R2 R4 R9 count";
    else             return "R3 hold";
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(posedge clk); #1;
    compare_all("R6 R7 reset state");

    // R10 reference sequence on the low stage
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h000, "R10 clear");
    step(1'b1, 1'b0, 1'b1, 1'b1, 12'h00C, "R10 preset 12");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R10 R4 count");
      chk(cnt_a[3:0] == 4'(13 + i), "R10 low stage sequence",
          {12'h0, cnt_a[3:0]}, {12'h0, 4'(13 + i)});
    end
    step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R10 R3 inhibit");
    chk(cnt_a[3:0] == 4'd2, "R10 hold after inhibit", {12'h0, cnt_a[3:0]}, 16'h2);

    // R5: cnt_en low does not kill the carry; carry_en low does
    step(1'b1, 1'b0, 1'b1, 1'b1, 12'h00F, "R1 load 15");
    step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R5 R3 par low");
    chk(co_a[0] == 1'b1, "R5 carry with cnt_en low", {15'h0, co_a[0]}, 16'h1);
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R5 R3 trk low");
    chk(co_s[0] == 1'b0, "R5 carry blocked by carry_en", {15'h0, co_s[0]}, 16'h0);

    // R9 / R4 full 12-bit wrap
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFE, "R1 load FFE");
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R2 R9 to FFF");
    chk(co_a[2] == 1'b1, "R9 top carry at max", {15'h0, co_a[2]}, 16'h1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R4 R9 wrap");
    chk(cnt_s == 12'h000 && co_s[2] == 1'b0, "R4 R9 wrapped to zero",
        {4'h0, cnt_s}, 16'h0);

    // R8: load wins over count, clear wins over load
    step(1'b1, 1'b0, 1'b1, 1'b1, 12'h5A3, "R8 load over count");
    step(1'b0, 1'b0, 1'b1, 1'b1, 12'h123, "R8 clear over load");

    // R6 vs R7: clear dropped mid-cycle
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'h7C4, "R1 load 7C4");
    @(negedge clk);
    clr_n = 1'b0; load_n = 1'b0; par = 1'b1; trk = 1'b1; din12 = 12'h999;
    #1;
    chk(cnt_a == 12'h000, "R6 async clear before edge", {4'h0, cnt_a}, 16'h0);
    chk(cnt_s == 12'h7C4, "R7 sync holds before edge", {4'h0, cnt_s}, 16'h7C4);
    @(posedge clk);
    model = '0;
    #1;
    compare_all("R6 R7 after edge");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic c, l, p, t;
      logic [11:0] d;
      c = ($urandom % 40) != 0;
      l = ($urandom % 12) != 0;
      p = ($urandom % 8) != 0;
      t = ($urandom % 8) != 0;
      d = 12'($urandom);
      if (($urandom % 5) == 0) d = 12'hFF0 | 12'($urandom % 16);
      step(c, l, p, t, d, mode_tag(c, l, p, t));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule